// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small accumulator-based controller. It takes the accumulator value, a second operand (the B register for multiply and divide) and an incoming carry. A 3-bit code selects one of eight operations: add, add with carry, subtract with borrow, AND, OR, XOR, unsigned multiply and unsigned divide. The results are combinational. `accOut` is the value bound for the accumulator, `bOut` is the value bound for the B register, and `product` is the full double-width product.

The status flags are registered. Carry, auxiliary carry and overflow are captured on the clock edge at which `opValid` is high. Parity is refreshed on every clock edge from the accumulator input alone. The flags are also presented as a status byte whose bit positions match the controller's status word. The bits of that word that this block does not own read as zero.

Instruction decode, register storage and decimal adjust belong to the surrounding controller.

Top module: `accAlu`

## Requirements
- R1: Opcode values are ADD=0, ADDC=1, SUBB=2, AND=3, OR=4, XOR=5, MUL=6, DIV=7. ADD gives `accOut` = (accIn + bIn) mod 256 combinationally and ignores carryIn. ADDC adds carryIn as well.
- R2: SUBB gives `accOut` = (accIn − bIn − carryIn) mod 256 combinationally.
- R3: On the edge where opValid is high with ADD, ADDC or SUBB, flagCy becomes the carry out of bit 7. For SUBB it is the borrow out of bit 7.
- R4: On that same edge, flagAc becomes the carry (or borrow) from bit 3 into bit 4.
- R5: On that same edge, flagOv becomes the XOR of the carry (or borrow) into bit 7 and the carry (or borrow) out of bit 7.
- R6: AND, OR and XOR give the bitwise result on `accOut`. A strobed logic operation leaves flagCy, flagAc and flagOv unchanged.
- R7: On every clock edge, whether or not opValid is high, flagPar becomes 1 when accIn holds an odd number of ones and 0 otherwise.
- R8: MUL puts the low product byte on `accOut` and the high byte on `bOut`, and shows the 16-bit product on `product`. When strobed, it clears flagCy, sets flagOv exactly when the product exceeds 255, and keeps flagAc. For every operation other than MUL and DIV, `bOut` equals bIn.
- R9: DIV with a nonzero divisor puts the quotient on `accOut` and the remainder on `bOut`. When strobed, it clears flagCy and flagOv and keeps flagAc. When the divisor is zero it clears flagCy, sets flagOv and leaves `accOut` and `bOut` undefined.
- R10: With opValid low, flagCy, flagAc and flagOv hold their values.
- R11: While rst_n is low, all four flags are 0.
- R12: `statusByte` holds flagCy at bit 7, flagAc at bit 6, flagOv at bit 2 and flagPar at bit 0. Bits 5, 4, 3 and 1 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| opValid | input | 1 | Strobe that commits the operation's flags at the clock edge |
| opSel | input | 3 | Operation code |
| accIn | input | 8 | Accumulator operand |
| bIn | input | 8 | Second operand / B register |
| carryIn | input | 1 | Incoming carry or borrow for ADDC and SUBB |
| accOut | output | 8 | Result bound for the accumulator |
| bOut | output | 8 | Result bound for B (product high byte, remainder, or bIn) |
| product | output | 16 | Full unsigned product |
| flagCy | output | 1 | Registered carry flag |
| flagAc | output | 1 | Registered auxiliary carry flag |
| flagOv | output | 1 | Registered overflow flag |
| flagPar | output | 1 | Registered accumulator parity |
| statusByte | output | 8 | Flags placed at their status-word positions |

## Verification
The bench builds the block at its default width of 8 bits. At that width the 4-bit boundary for the auxiliary carry and the bit-6 and bit-7 carries for overflow can be driven on purpose with chosen operands. The same width lets the 255 product threshold and the all-ones operands be hit exactly. It also keeps the divider small enough to check a zero divisor alongside ordinary quotients and remainders.

// File: rtl/accAluPkg.sv
package accAluPkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_MUL  = 3'd6,
    OP_DIV  = 3'd7
  } aluOp_t;

  typedef enum logic [2:0] {
    RES_SUM = 3'd0,
    RES_AND = 3'd1,
    RES_OR  = 3'd2,
    RES_XOR = 3'd3,
    RES_MUL = 3'd4,
    RES_DIV = 3'd5
  } resSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    updArith;   // commit CY/AC/OV from adder
    logic    updMulDiv;  // commit CY=0, OV from mul/div
    logic    subtract;   // adder runs as subtractor
    logic    useCarry;   // carryIn feeds the adder
    resSel_t resSel;     // result source
  } aluStrobe_t;

endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic       opValid,
  input  aluOp_t     op,
  output aluStrobe_t stb
);

  always_comb begin
    stb = '{updArith: 1'b0, updMulDiv: 1'b0, subtract: 1'b0,
            useCarry: 1'b0, resSel: RES_SUM};
    unique case (op)
      OP_ADD:  stb.updArith = opValid;
      OP_ADDC: begin
        stb.updArith = opValid;
        stb.useCarry = 1'b1;
      end
      OP_SUBB: begin
        stb.updArith = opValid;
        stb.useCarry = 1'b1;
        stb.subtract = 1'b1;
      end
      OP_AND:  stb.resSel = RES_AND;
      OP_OR:   stb.resSel = RES_OR;
      OP_XOR:  stb.resSel = RES_XOR;
      OP_MUL:  begin
        stb.resSel    = RES_MUL;
        stb.updMulDiv = opValid;
      end
      OP_DIV:  begin
        stb.resSel    = RES_DIV;
        stb.updMulDiv = opValid;
      end
      default: stb.resSel = RES_SUM;
    endcase
  end

endmodule

// File: rtl/accAluDp.sv
module accAluDp
  import accAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  aluStrobe_t         stb,
  input  logic [WIDTH-1:0]   accIn,
  input  logic [WIDTH-1:0]   bIn,
  input  logic               carryIn,
  output logic [WIDTH-1:0]   accOut,
  output logic [WIDTH-1:0]   bOut,
  output logic [2*WIDTH-1:0] product,
  output logic               flagCy,
  output logic               flagAc,
  output logic               flagOv,
  output logic               flagPar
);

  localparam int HALF = WIDTH / 2;
  localparam int PW   = 2 * WIDTH;

  // ---------------- shared adder / subtractor ----------------
  logic [WIDTH-1:0] bEff;
  logic             cEff;
  logic [WIDTH:0]   sumFull;
  logic             carryIntoHalf;
  logic             carryIntoTop;
  logic             carryOutTop;

  always_comb begin
    bEff    = stb.subtract ? ~bIn : bIn;
    cEff    = stb.useCarry ? (carryIn ^ stb.subtract) : stb.subtract;
    sumFull = {1'b0, accIn} + {1'b0, bEff} + {{WIDTH{1'b0}}, cEff};
    // carry into a bit position recovered from sum and operands
    carryIntoHalf = sumFull[HALF] ^ accIn[HALF] ^ bEff[HALF];
    carryIntoTop  = sumFull[WIDTH-1] ^ accIn[WIDTH-1] ^ bEff[WIDTH-1];
    carryOutTop   = sumFull[WIDTH];
  end

  // ---------------- multiplier ----------------
  logic [PW-1:0] mulFull;
  assign mulFull = {{WIDTH{1'b0}}, accIn} * {{WIDTH{1'b0}}, bIn};
  assign product = mulFull;

  // ---------------- restoring divider, one stage per quotient bit ----------------
  logic [WIDTH-1:0] remStage [0:WIDTH];
  logic [WIDTH-1:0] quot;
  assign remStage[0] = '0;

  for (genvar s = 0; s < WIDTH; s++) begin : g_divStage
    logic [WIDTH:0] trial;
    logic           fits;
    assign trial = {remStage[s], accIn[WIDTH-1-s]};
    assign fits  = (trial >= {1'b0, bIn});
    assign quot[WIDTH-1-s] = fits;
    always_comb begin
      if (fits) remStage[s+1] = trial[WIDTH-1:0] - bIn;
      else      remStage[s+1] = trial[WIDTH-1:0];
    end
  end

  logic divZero;
  assign divZero = (bIn == '0);

  // ---------------- result mux ----------------
  always_comb begin
    bOut = bIn;
    unique case (stb.resSel)
      RES_SUM: accOut = sumFull[WIDTH-1:0];
      RES_AND: accOut = accIn & bIn;
      RES_OR:  accOut = accIn | bIn;
      RES_XOR: accOut = accIn ^ bIn;
      RES_MUL: begin
        accOut = mulFull[WIDTH-1:0];
        bOut   = mulFull[PW-1:WIDTH];
      end
      RES_DIV: begin
        accOut = quot;
        bOut   = remStage[WIDTH];
      end
      default: accOut = sumFull[WIDTH-1:0];
    endcase
  end

  // ---------------- flag register ----------------
  logic mdOv;
  assign mdOv = (stb.resSel == RES_DIV) ? divZero : (mulFull[PW-1:WIDTH] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagCy  <= 1'b0;
      flagAc  <= 1'b0;
      flagOv  <= 1'b0;
      flagPar <= 1'b0;
    end else begin
      flagPar <= ^accIn;
      if (stb.updArith) begin
        flagCy <= carryOutTop ^ stb.subtract;
        flagAc <= carryIntoHalf ^ stb.subtract;
        flagOv <= carryIntoTop ^ carryOutTop;
      end else if (stb.updMulDiv) begin
        flagCy <= 1'b0;
        flagOv <= mdOv;
      end
    end
  end

endmodule

// File: rtl/accAlu.sv
module accAlu
  import accAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               opValid,
  input  logic [2:0]         opSel,
  input  logic [WIDTH-1:0]   accIn,
  input  logic [WIDTH-1:0]   bIn,
  input  logic               carryIn,
  output logic [WIDTH-1:0]   accOut,
  output logic [WIDTH-1:0]   bOut,
  output logic [2*WIDTH-1:0] product,
  output logic               flagCy,
  output logic               flagAc,
  output logic               flagOv,
  output logic               flagPar,
  output logic [7:0]         statusByte
);

  aluStrobe_t stb;

  accAluCtrl u_ctrl (
    .opValid (opValid),
    .op      (aluOp_t'(opSel)),
    .stb     (stb)
  );

  accAluDp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .accIn   (accIn),
    .bIn     (bIn),
    .carryIn (carryIn),
    .accOut  (accOut),
    .bOut    (bOut),
    .product (product),
    .flagCy  (flagCy),
    .flagAc  (flagAc),
    .flagOv  (flagOv),
    .flagPar (flagPar)
  );

  // status-word positions: CY7 AC6 OV2 P0; other bits owned elsewhere
  assign statusByte = {flagCy, flagAc, 3'b000, flagOv, 1'b0, flagPar};

endmodule

// File: rtl/accAluChk.sv
module accAluChk
  import accAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               opValid,
  input logic [2:0]         opSel,
  input logic [WIDTH-1:0]   accIn,
  input logic [WIDTH-1:0]   bIn,
  input logic               carryIn,
  input logic [WIDTH-1:0]   accOut,
  input logic [WIDTH-1:0]   bOut,
  input logic [2*WIDTH-1:0] product,
  input logic               flagCy,
  input logic               flagAc,
  input logic               flagOv,
  input logic               flagPar,
  input logic [7:0]         statusByte
);

  localparam logic [WIDTH:0] TOPVAL = {1'b1, {WIDTH{1'b0}}};

  a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opSel == OP_ADD) |=>
      flagCy == (({1'b0, $past(accIn)} + {1'b0, $past(bIn)}) >= TOPVAL));

  a_r2_subb_result: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OP_SUBB) |->
      (accOut + bIn + {{(WIDTH-1){1'b0}}, carryIn}) == accIn);

  a_r6_logic_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR)) |=>
      (flagCy == $past(flagCy) && flagAc == $past(flagAc) && flagOv == $past(flagOv)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> ($stable(flagCy) && $stable(flagAc) && $stable(flagOv)));

  a_r7_parity: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flagPar == (($countones($past(accIn)) % 2) == 1));

  a_r8_mul_split: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OP_MUL) |-> ({bOut, accOut} == product &&
      product == {{WIDTH{1'b0}}, accIn} * {{WIDTH{1'b0}}, bIn}));

  a_r8_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opSel == OP_MUL) |=> (!flagCy && flagAc == $past(flagAc)));

  a_r9_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OP_DIV && bIn != '0) |->
      (bOut < bIn && ({{WIDTH{1'b0}}, accOut} * {{WIDTH{1'b0}}, bIn}
                      + {{WIDTH{1'b0}}, bOut}) == {{WIDTH{1'b0}}, accIn}));

  a_r9_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opSel == OP_DIV && bIn == '0) |=> (flagOv && !flagCy));

  a_r12_status_map: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (statusByte[7] == flagCy && statusByte[6] == flagAc &&
              statusByte[2] == flagOv && statusByte[0] == flagPar &&
              statusByte[5:3] == 3'b000 && !statusByte[1]));

endmodule

bind accAlu accAluChk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/accAlu_test.sv
module accAlu_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        opValid;
  logic [2:0]  opSel;
  logic [7:0]  accIn;
  logic [7:0]  bIn;
  logic        carryIn;
  logic [7:0]  accOut;
  logic [7:0]  bOut;
  logic [15:0] product;
  logic        flagCy, flagAc, flagOv, flagPar;
  logic [7:0]  statusByte;

  int total = 0;
  int bad   = 0;
  logic expCy = 0, expAc = 0, expOv = 0;

  always #5 clk = ~clk;

  accAlu uut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opSel(opSel),
    .accIn(accIn), .bIn(bIn), .carryIn(carryIn), .accOut(accOut),
    .bOut(bOut), .product(product), .flagCy(flagCy), .flagAc(flagAc),
    .flagOv(flagOv), .flagPar(flagPar), .statusByte(statusByte)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one operation, check combinational results, clock it, check flags
  task automatic doOp(input string tag, input logic [2:0] op, input int a,
                      input int b, input logic cin);
    int c, s, lo, mid, prod;
    logic [7:0] expAcc, expB;
    logic chkB, chkAcc;
    chkB = 1'b1; chkAcc = 1'b1; expB = b[7:0];
    c = (op == 1 || op == 2) ? int'(cin) : 0;
    case (op)
      0, 1: begin
        s = a + b + c; lo = (a & 15) + (b & 15) + c; mid = (a & 127) + (b & 127) + c;
        expAcc = s[7:0]; expCy = s > 255; expAc = lo > 15; expOv = (s > 255) ^ (mid > 127);
      end
      2: begin
        s = a - b - c; lo = (a & 15) - (b & 15) - c; mid = (a & 127) - (b & 127) - c;
        expAcc = s[7:0]; expCy = s < 0; expAc = lo < 0; expOv = (s < 0) ^ (mid < 0);
      end
      3: expAcc = a[7:0] & b[7:0];
      4: expAcc = a[7:0] | b[7:0];
      5: expAcc = a[7:0] ^ b[7:0];
      6: begin
        prod = a * b; expAcc = prod[7:0]; expB = prod[15:8];
        expCy = 0; expOv = prod > 255;
      end
      default: begin
        expCy = 0;
        if (b == 0) begin expOv = 1; chkB = 0; chkAcc = 0; end
        else begin expOv = 0; expAcc = 8'(a / b); expB = 8'(a % b); end
      end
    endcase
    @(negedge clk);
    opSel = op; accIn = a[7:0]; bIn = b[7:0]; carryIn = cin; opValid = 1'b1;
    #2;
    if (chkAcc) check({tag, " accOut"}, accOut, expAcc);
    if (chkB)   check({tag, " bOut"}, bOut, expB);
    if (op == 6) check({tag, " product"}, product, 32'(a * b));
    @(negedge clk);
    opValid = 1'b0;
    check({tag, " flags CY/AC/OV"}, {flagCy, flagAc, flagOv}, {expCy, expAc, expOv});
    check({tag, " R7 parity"}, flagPar, ($countones(a[7:0]) % 2) == 1);
  endtask

  task automatic testReset();
    rst_n = 1'b0; opValid = 1'b0; opSel = 3'd0; accIn = 8'hFF; bIn = 8'hFF; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 flags in reset", {flagCy, flagAc, flagOv, flagPar}, 4'b0000);
    check("R12 status byte in reset", statusByte, 8'h00);
    accIn = 8'h00; carryIn = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic testAdd();
    doOp("R1 R3 add plain",        3'd0, 8'h12, 8'h34, 1'b1); // carryIn ignored
    doOp("R4 add nibble carry",    3'd0, 8'h0F, 8'h01, 1'b0);
    doOp("R5 add signed overflow", 3'd0, 8'h7F, 8'h01, 1'b0);
    doOp("R3 add wrap to zero",    3'd0, 8'hFF, 8'h01, 1'b0);
    doOp("R5 add two negatives",   3'd0, 8'h80, 8'h80, 1'b0);
    doOp("R1 addc with carry",     3'd1, 8'hFE, 8'h01, 1'b1);
    doOp("R1 addc carry no effect",3'd1, 8'h20, 8'h05, 1'b0);
  endtask

  task automatic testSub();
    doOp("R2 R3 subb underflow",   3'd2, 8'h00, 8'h01, 1'b0);
    doOp("R5 subb signed overflow",3'd2, 8'h80, 8'h01, 1'b0);
    doOp("R4 subb nibble borrow",  3'd2, 8'h10, 8'h01, 1'b0);
    doOp("R2 subb borrow in",      3'd2, 8'h50, 8'h20, 1'b1);
    doOp("R2 subb equal no borrow",3'd2, 8'h33, 8'h33, 1'b0);
  endtask

  task automatic testLogic();
    doOp("R3 set flags before logic", 3'd0, 8'h88, 8'h88, 1'b0); // CY=1 AC=1 OV=1
    doOp("R6 and keeps flags", 3'd3, 8'hF0, 8'h3C, 1'b1);
    doOp("R6 or keeps flags",  3'd4, 8'hA0, 8'h05, 1'b0);
    doOp("R6 xor keeps flags", 3'd5, 8'hFF, 8'h0F, 1'b0);
  endtask

  task automatic testMul();
    doOp("R8 mul small",         3'd6, 8'h03, 8'h05, 1'b0);
    doOp("R8 mul exactly 256",   3'd6, 8'h10, 8'h10, 1'b0);
    doOp("R8 mul max",           3'd6, 8'hFF, 8'hFF, 1'b0);
    doOp("R8 bOut passthrough",  3'd0, 8'h01, 8'h5A, 1'b0);
  endtask

  task automatic testDiv();
    doOp("R9 div regular",      3'd7, 100, 7, 1'b0);
    doOp("R9 div by zero",      3'd7, 5, 0, 1'b0);
    doOp("R9 div zero dividend",3'd7, 0, 3, 1'b0);
    doOp("R9 div by one",       3'd7, 8'hFF, 1, 1'b0);
  endtask

  task automatic testIdle();
    doOp("R10 prime flags", 3'd0, 8'hFF, 8'h81, 1'b0); // CY=1 AC=1 OV=0
    @(negedge clk);
    opValid = 1'b0; opSel = 3'd2; accIn = 8'h07; bIn = 8'h00; carryIn = 1'b0;
    @(negedge clk);
    check("R10 idle keeps flags", {flagCy, flagAc, flagOv}, {expCy, expAc, expOv});
    check("R7 parity idle odd", flagPar, 1'b1);
    accIn = 8'h03;
    @(negedge clk);
    check("R7 parity idle even", flagPar, 1'b0);
    check("R12 status byte layout", statusByte, {expCy, expAc, 3'b000, expOv, 1'b0, 1'b0});
  endtask

  initial begin
    testReset();
    testAdd();
    testSub();
    testLogic();
    testMul();
    testDiv();
    testIdle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule